// File: doc/BRIEF.md
# Low-Power Mode Controller with Settling Timer

This block sequences the power states of a small processor. Software programs an 8-bit control register. It holds a standby enable, a 3-bit hold-time code and a bus drive enable. While the processor runs, a speed select input moves it between high-speed, medium-speed and sub-clock operation. When the core reports a sleep instruction, the block picks a low-power state. The choice depends on the standby enable and on the state the core is leaving.

Light sleep states return to the state they came from on the first wake event. The same holds for the sub-clock watch state. Full standby stops the main clock. On wake from full standby, a down-counter runs for the programmed number of clock states so that the oscillator can settle, and the core is released only after that. A bus drive output tells the pad logic whether the address bus and bus control lines stay driven or float while the clock is stopped.

The parameter `HOLD_SHIFT` divides the long hold counts by a power of two. This keeps short simulations practical. It must stay at 13 or below so that no count becomes zero.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, `reg_rd_data` reads 0x08, `mode` is 0 (high-speed), and `cpu_halt` and `clk_stop` are 0. `bus_oe` is 1 and `tsel_rsvd` is 0.
- R2: A write stores data bits 7..3: bit 7 is standby enable, bits 6..4 are the hold code, and bit 3 is bus drive enable. Bits 2..0 always read 0. Without a write, the register holds its value.
- R3: The mode codes are 0 high-speed, 1 medium, 2 sub-clock, 3 sleep, 4 sub-sleep, 5 standby, 6 watch and 7 settling. In modes 0 to 2 without a sleep request, `speed_sel` values 0, 1 and 2 move to that mode on the next cycle, and value 3 keeps the mode.
- R4: A sleep request with standby enable at 0 moves modes 0 and 1 to mode 3, and mode 2 to mode 4, on the next cycle.
- R5: A sleep request with standby enable at 1 moves modes 0 and 1 to mode 5, and mode 2 to mode 6, on the next cycle.
- R6: A wake event moves mode 3 back to the mode it was entered from, and modes 4 and 6 back to mode 2, on the next cycle, with no hold delay.
- R7: A wake event in mode 5 enters mode 7, which lasts exactly N cycles before returning to the mode standby was entered from. N is given by the hold code at the wake: codes 0 to 5 give (8192 << code) >> HOLD_SHIFT, and code 7 gives 16.
- R8: Hold code 6 is reserved. It gives the same count as code 5, and `tsel_rsvd` is 1 exactly while the register holds code 6.
- R9: `clk_stop` is 1 exactly in modes 5 and 6. `cpu_halt` is 1 exactly in modes 3 to 7.
- R10: `bus_oe` is 0 only in modes 5 and 6 while bus drive enable is 0. Otherwise it is 1.
- R11: `wake_irq` has no effect in modes 0 to 2. `sleep_req` and `speed_sel` have no effect in modes 3 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| speed_sel | input | 2 | Requested run speed (3 = hold) |
| sleep_req | input | 1 | Core executed a sleep instruction |
| wake_irq | input | 1 | Wake-up event |
| reg_rd_data | output | 8 | Control register read value |
| mode | output | 3 | Current mode code |
| clk_stop | output | 1 | Main clock stop request |
| cpu_halt | output | 1 | Core held off |
| bus_oe | output | 1 | Address and bus control drive enable |
| tsel_rsvd | output | 1 | Reserved hold code selected |

## Verification
The assertions assume that reset is held low for at least one clock edge before any property is judged. They also assume that `sleep_req` and `wake_irq` are sampled as plain one-cycle levels, with no handshake. The stimulus changes inputs only away from the clock edge. Sleep and wake requests, register writes and speed changes are drawn at independent random rates, so they also collide in the same cycle, which exercises the precedence of a sleep request over a speed change and the use of the register value from before a write. Directed runs time every hold code, the reserved code included, from the wake edge to the release.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int unsigned HOLD_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wr_data,
  input  logic [1:0] speed_sel,
  input  logic       sleep_req,
  input  logic       wake_irq,
  output logic [7:0] reg_rd_data,
  output logic [2:0] mode,
  output logic       clk_stop,
  output logic       cpu_halt,
  output logic       bus_oe,
  output logic       tsel_rsvd
);
  localparam int CW = 19;
  localparam logic [2:0] M_HIGH = 3'd0, M_MED = 3'd1, M_SUB = 3'd2, M_SLEEP = 3'd3,
                         M_SSLP = 3'd4, M_STBY = 3'd5, M_WATCH = 3'd6, M_SETTLE = 3'd7;

  logic [4:0]    ctl;
  logic [2:0]    mode_n, home;
  logic [CW-1:0] cnt;

  wire       ssby = ctl[4];
  wire [2:0] tsel = ctl[3:1];
  wire       ope  = ctl[0];
  wire       run  = (mode <= M_SUB);

  function automatic logic [CW-1:0] hold_len(input logic [2:0] c);
    logic [CW-1:0] base;
    base = CW'(8192);
    case (c)
      3'd7:    return CW'(16);
      3'd6:    return (base << 5) >> HOLD_SHIFT;
      default: return (base << c) >> HOLD_SHIFT;
    endcase
  endfunction

  always_comb begin
    mode_n = mode;
    case (mode)
      M_HIGH, M_MED, M_SUB:
        if (sleep_req)
          mode_n = (mode == M_SUB) ? (ssby ? M_WATCH : M_SSLP) : (ssby ? M_STBY : M_SLEEP);
        else if (speed_sel != 2'd3)
          mode_n = {1'b0, speed_sel};
      M_SLEEP:  if (wake_irq) mode_n = home;
      M_SSLP,
      M_WATCH:  if (wake_irq) mode_n = M_SUB;
      M_STBY:   if (wake_irq) mode_n = M_SETTLE;
      M_SETTLE: if (cnt == CW'(1)) mode_n = home;
      default:  mode_n = M_HIGH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl  <= 5'b00001;
      mode <= M_HIGH;
      home <= M_HIGH;
      cnt  <= '0;
    end else begin
      mode <= mode_n;
      if (reg_wr_en) ctl <= reg_wr_data[7:3];
      if (run && sleep_req) home <= mode;
      if (mode == M_STBY && wake_irq) cnt <= hold_len(tsel);
      else if (mode == M_SETTLE) cnt <= cnt - CW'(1);
    end
  end

  assign reg_rd_data = {ctl, 3'b000};
  assign clk_stop    = (mode == M_STBY) || (mode == M_WATCH);
  assign cpu_halt    = !run;
  assign bus_oe      = !clk_stop || ope;
  assign tsel_rsvd   = (tsel == 3'd6);

  a_r2_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(reg_rd_data));
  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HIGH || mode == M_MED) && sleep_req && !reg_rd_data[7] |=> mode == M_SLEEP);
  a_r5_watch_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_SUB && sleep_req && reg_rd_data[7] |=> mode == M_WATCH);
  a_r6_sleep_return: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_SLEEP && wake_irq |=> mode == $past(home) && !cpu_halt);
  a_r7_settle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_SETTLE && cnt != CW'(1) |=> mode == M_SETTLE);
  a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> cpu_halt);
  a_r11_run_wake: assert property (@(posedge clk) disable iff (!rst_n)
    run && wake_irq && !sleep_req && speed_sel == 2'd3 |=> $stable(mode));
endmodule

// File: tb/pwr_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctl_tb_top;
  localparam int SHIFT = 6;
  logic clk = 0, rst_n = 0, reg_wr_en = 0, sleep_req = 0, wake_irq = 0;
  logic [7:0] reg_wr_data = 0;
  logic [1:0] speed_sel = 2'd3;
  logic [7:0] reg_rd_data;
  logic [2:0] mode;
  logic clk_stop, cpu_halt, bus_oe, tsel_rsvd;
  int errs = 0, checks = 0;
  bit done = 0;

  int m_reg, m_mode, m_home, m_cnt;

  always #2.5 clk = ~clk;

  pwr_mode_ctl #(.HOLD_SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .speed_sel(speed_sel), .sleep_req(sleep_req), .wake_irq(wake_irq),
    .reg_rd_data(reg_rd_data), .mode(mode), .clk_stop(clk_stop), .cpu_halt(cpu_halt),
    .bus_oe(bus_oe), .tsel_rsvd(tsel_rsvd));

  function automatic int hold_n(input int code);
    if (code == 7) return 16;
    if (code == 6) code = 5;
    return (8192 << code) >> SHIFT;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic m_step();
    int nm;
    if (!rst_n) begin
      m_reg = 8'h08; m_mode = 0; m_home = 0; m_cnt = 0;
      return;
    end
    nm = m_mode;
    if (m_mode <= 2) begin
      if (sleep_req) begin
        m_home = m_mode;
        if (m_mode == 2) nm = m_reg[7] ? 6 : 4;
        else nm = m_reg[7] ? 5 : 3;
      end else if (speed_sel != 3) nm = speed_sel;
    end else if (m_mode == 3) begin
      if (wake_irq) nm = m_home;
    end else if (m_mode == 4 || m_mode == 6) begin
      if (wake_irq) nm = 2;
    end else if (m_mode == 5) begin
      if (wake_irq) begin nm = 7; m_cnt = hold_n((m_reg >> 4) & 7); end
    end else begin
      m_cnt--;
      if (m_cnt == 0) nm = m_home;
    end
    m_mode = nm;
    if (reg_wr_en) m_reg = reg_wr_data & 8'hF8;
  endtask

  task automatic compare_all();
    int stop;
    stop = (m_mode == 5 || m_mode == 6);
    check("R2 reg", reg_rd_data, m_reg);
    check("R3 mode", mode, m_mode);
    check("R9 clk_stop", clk_stop, stop);
    check("R9 cpu_halt", cpu_halt, m_mode >= 3);
    check("R10 bus_oe", bus_oe, (!stop || m_reg[3]) ? 1 : 0);
    check("R8 tsel_rsvd", tsel_rsvd, ((m_reg >> 4) & 7) == 6);
  endtask

  task automatic cyc();
    @(posedge clk);
    m_step();
    #1;
    compare_all();
  endtask

  task automatic drive(input bit wr, input int data, input int spd, input bit slp, input bit wk);
    reg_wr_en = wr; reg_wr_data = 8'(data); speed_sel = 2'(spd); sleep_req = slp; wake_irq = wk;
    cyc();
    reg_wr_en = 0; speed_sel = 2'd3; sleep_req = 0; wake_irq = 0;
  endtask

  task automatic time_settle(input int code, input int home_mode);
    int n;
    drive(1, 8'h88 | (code << 4), 3, 0, 0);
    check("R8 rsvd flag", tsel_rsvd, code == 6);
    drive(0, 0, 3, 1, 0);
    check("R5 standby", mode, 5);
    check("R10 driven", bus_oe, 1);
    drive(0, 0, 3, 0, 1);
    check("R9 settle clk", clk_stop, 0);
    n = 1;
    while (mode == 7 && n < 300000) begin
      cyc();
      if (mode == 7) n++;
    end
    check("R7 hold count", n, hold_n(code));
    check("R7 return mode", mode, home_mode);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    rst_n = 1;
    #1;
    check("R1 reg", reg_rd_data, 8'h08);
    check("R1 mode", mode, 0);
    check("R1 halt", cpu_halt, 0);
    check("R1 stop", clk_stop, 0);
    check("R1 oe", bus_oe, 1);
    check("R1 rsvd", tsel_rsvd, 0);

    drive(1, 8'hFF, 3, 0, 0);
    check("R2 write", reg_rd_data, 8'hF8);
    drive(1, 8'h08, 3, 0, 0);
    drive(0, 0, 1, 0, 0);
    check("R3 speed", mode, 1);
    drive(0, 0, 3, 0, 0);
    check("R3 hold", mode, 1);
    drive(0, 0, 3, 0, 1);
    check("R11 wake run", mode, 1);
    drive(0, 0, 3, 1, 0);
    check("R4 sleep", mode, 3);
    drive(0, 0, 0, 1, 0);
    check("R11 ignored", mode, 3);
    drive(0, 0, 3, 0, 1);
    check("R6 return", mode, 1);
    drive(0, 0, 2, 0, 0);
    drive(0, 0, 3, 1, 0);
    check("R4 subsleep", mode, 4);
    drive(0, 0, 3, 0, 1);
    check("R6 sub return", mode, 2);
    drive(1, 8'h80, 3, 0, 0);
    drive(0, 0, 3, 1, 0);
    check("R5 watch", mode, 6);
    check("R9 stop", clk_stop, 1);
    check("R10 float", bus_oe, 0);
    drive(0, 0, 3, 0, 1);
    check("R6 watch return", mode, 2);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 3, 1, 0);
    check("R5 standby", mode, 5);
    check("R10 float stby", bus_oe, 0);
    drive(0, 0, 3, 1, 0);
    check("R11 sleep in stby", mode, 5);
    drive(0, 0, 3, 0, 1);
    check("R9 halt settle", cpu_halt, 1);
    while (mode == 7) cyc();
    check("R7 back", mode, 0);
    for (int c = 1; c < 8; c++) time_settle(c, 0);
    drive(0, 0, 1, 0, 0);
    time_settle(0, 1);

    for (int i = 0; i < 6000; i++) begin
      reg_wr_en = ($urandom % 16) == 0;
      reg_wr_data = 8'($urandom);
      speed_sel = (($urandom % 4) == 0) ? 2'($urandom) : 2'd3;
      sleep_req = ($urandom % 8) == 0;
      wake_irq = ($urandom % 12) == 0;
      if (i % 1500 == 700) begin rst_n = 0; cyc(); rst_n = 1; end
      else cyc();
    end
    reg_wr_en = 0; sleep_req = 0; wake_irq = 0; speed_sel = 2'd3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule